// File: doc/BRIEF.md
# Battery Monitor Power Mode Sequencer

This block keeps track of which power state a battery monitor is in: normal, sleep or shutdown. It also tells the rest of the monitor when to run one round of measurement, calculation, protection checks and data update. A slow one-second timebase tick paces everything. In normal mode every tick produces a one-cycle measurement strobe. In sleep mode the strobe comes only once every programmable number of ticks.

Sleep ends in one of two ways. The first is current flow: the magnitude of a signed sense-voltage sample reaches one of four selectable wake thresholds, and this works for charge and discharge alike. The second is an asserted fault input. In shutdown nothing runs. The block leaves shutdown only when the flag saying the pack input has reached the startup voltage goes high.

The block also samples an active-low host-present input on each tick while it is awake. Sense samples arrive with a valid qualifier and are always accepted, so there is no back-pressure. Samples with valid low are ignored. All other pins are plain levels.

Top module: `gauge_pwr_seq`

## Requirements
- R1: After reset, `pm_mode` is 0 (normal), `meas_stb` is 0 and `sys_present` is 0.
- R2: In normal mode, each cycle with `sec_tick` high is followed by `meas_stb` high for exactly the next cycle. `meas_stb` is never high in a cycle not preceded by an accepted tick.
- R3: In normal mode, `shut_req` moves `pm_mode` to 2 (shutdown) on the next cycle. Otherwise `sleep_req` moves it to 1 (sleep). `shut_req` wins when both are high.
- R4: In sleep mode, a strobe follows every Nth tick, where N is `sleep_ival`. A value of 0 acts as 1. The tick count restarts from zero on every entry into sleep.
- R5: In sleep mode, a sample with `smp_valid` high and |`smp_data`| >= the selected threshold returns `pm_mode` to 0 on the next cycle. This holds for positive and negative samples. With the default 0.25 mV per LSB, the thresholds in LSB for `wake_sel` 0, 1, 2 and 3 are 4, 9, 18 and 36 (1.00, 2.25, 4.5 and 9 mV).
- R6: In sleep mode, `fault` returns `pm_mode` to 0 on the next cycle. A tick in the same cycle as any wake gives no strobe. The next tick after the wake gives a strobe, because the block is then in normal mode.
- R7: In shutdown mode no strobe is issued, and `sleep_req`, `fault`, samples and ticks have no effect. `startup_ok` high moves `pm_mode` to 0 on the next cycle.
- R8: In sleep mode, `shut_req` moves `pm_mode` to 2 on the next cycle, even when a wake condition is present in the same cycle.
- R9: On each tick outside shutdown, `sys_present` takes the inverse of `host_pres_n`. It holds its value between ticks and throughout shutdown.
- R10: In sleep mode, a sample whose magnitude is below the selected threshold, or any sample with `smp_valid` low, leaves `pm_mode` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse per second from the slow timebase |
| smp_valid | input | 1 | Sense sample valid; always accepted |
| smp_data | input | SMP_W | Signed sense-voltage sample, two's complement |
| wake_sel | input | 2 | Wake threshold select (0..3) |
| sleep_ival | input | IVL_W | Sleep strobe interval in ticks (0 acts as 1) |
| fault | input | 1 | Failure flag; wakes from sleep |
| sleep_req | input | 1 | Request to enter sleep from normal |
| shut_req | input | 1 | Request to enter shutdown |
| startup_ok | input | 1 | Pack input at startup voltage; exits shutdown |
| host_pres_n | input | 1 | Host-present input, low means present |
| pm_mode | output | 2 | Mode: 0 normal, 1 sleep, 2 shutdown |
| meas_stb | output | 1 | One-cycle measurement strobe |
| sys_present | output | 1 | Registered host-present status |

## Verification
The bench aims at the threshold edges from both sides. It applies samples exactly equal to a threshold, one LSB below it, and negative samples. A design with a strict comparison, or one that took the two's-complement magnitude wrongly, would stay asleep or wake on the wrong side. A tick arriving in the same cycle as a fault is checked to give no strobe. The interval is checked at 0 and across a wake that interrupts the count, so a design that kept a stale count or counted a zero interval as 256 ticks would strobe at the wrong tick. Shutdown is driven together with a wake, and then fed sleep requests, faults, ticks and host-present changes. A design with the wrong priority or a leaky shutdown would leave the mode or change the status.

// File: rtl/gauge_pwr_pkg.sv
package gauge_pwr_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL   = 2'd0,
    PM_SLEEP    = 2'd1,
    PM_SHUTDOWN = 2'd2
  } pm_mode_e;

  localparam int N_THR = 4;

  // wake threshold in microvolts for each select code
  function automatic int thr_uv(input int idx);
    case (idx)
      0:       return 1000;
      1:       return 2250;
      2:       return 4500;
      default: return 9000;
    endcase
  endfunction

  function automatic int thr_lsb(input int idx, input int lsb_uv);
    return thr_uv(idx) / lsb_uv;
  endfunction
endpackage

// File: rtl/gauge_wake_det.sv
module gauge_wake_det
  import gauge_pwr_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int LSB_UV = 250
) (
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [1:0]       wake_sel,
  output logic             cur_wake
);
  localparam int MAG_W = SMP_W + 1;

  logic [MAG_W-1:0] mag;
  logic [N_THR-1:0] over;

  always_comb begin
    if (smp_data[SMP_W-1])
      mag = {1'b0, ~smp_data} + {{SMP_W{1'b0}}, 1'b1};
    else
      mag = {1'b0, smp_data};
  end

  for (genvar i = 0; i < N_THR; i++) begin : g_thr
    localparam int THR = thr_lsb(i, LSB_UV);
    assign over[i] = (mag >= MAG_W'(THR));
  end

  assign cur_wake = smp_valid & over[wake_sel];
endmodule

// File: rtl/gauge_ival_timer.sv
module gauge_ival_timer #(
  parameter int IVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick_en,
  input  logic [IVL_W-1:0] ival,
  output logic             due
);
  logic [IVL_W-1:0] cnt;
  logic [IVL_W-1:0] eff;

  assign eff = (ival == '0) ? IVL_W'(1) : ival;
  assign due = tick_en && (cnt >= eff - IVL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick_en) cnt <= due ? '0 : cnt + IVL_W'(1);
  end
endmodule

// File: rtl/gauge_pwr_seq.sv
module gauge_pwr_seq
  import gauge_pwr_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int IVL_W  = 8,
  parameter int LSB_UV = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [1:0]       wake_sel,
  input  logic [IVL_W-1:0] sleep_ival,
  input  logic             fault,
  input  logic             sleep_req,
  input  logic             shut_req,
  input  logic             startup_ok,
  input  logic             host_pres_n,
  output logic [1:0]       pm_mode,
  output logic             meas_stb,
  output logic             sys_present
);
  pm_mode_e mode_q, mode_d;
  logic     cur_wake, wake, in_sleep, due, stb_d;

  gauge_wake_det #(.SMP_W(SMP_W), .LSB_UV(LSB_UV)) u_wake (
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .wake_sel  (wake_sel),
    .cur_wake  (cur_wake)
  );

  assign in_sleep = (mode_q == PM_SLEEP);
  assign wake     = cur_wake | fault;

  gauge_ival_timer #(.IVL_W(IVL_W)) u_ival (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!in_sleep),
    .tick_en (sec_tick && in_sleep && !wake),
    .ival    (sleep_ival),
    .due     (due)
  );

  always_comb begin
    mode_d = mode_q;
    stb_d  = 1'b0;
    case (mode_q)
      PM_NORMAL: begin
        stb_d = sec_tick;
        if (shut_req)       mode_d = PM_SHUTDOWN;
        else if (sleep_req) mode_d = PM_SLEEP;
      end
      PM_SLEEP: begin
        stb_d = due;
        if (shut_req)  mode_d = PM_SHUTDOWN;
        else if (wake) mode_d = PM_NORMAL;
      end
      PM_SHUTDOWN: begin
        if (startup_ok) mode_d = PM_NORMAL;
      end
      default: mode_d = PM_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= PM_NORMAL;
      meas_stb    <= 1'b0;
      sys_present <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      meas_stb <= stb_d;
      if (sec_tick && mode_q != PM_SHUTDOWN)
        sys_present <= ~host_pres_n;
    end
  end

  assign pm_mode = mode_q;
endmodule

// File: rtl/gauge_pwr_seq_chk.sv
module gauge_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_tick,
  input logic       fault,
  input logic       shut_req,
  input logic       startup_ok,
  input logic [1:0] pm_mode,
  input logic       meas_stb
);
  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pm_mode != 2'd3);

  assert_stb_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd0 && sec_tick) |=> meas_stb);

  assert_no_stray_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !meas_stb);

  assert_fault_wakes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd1 && fault && !shut_req) |=> (pm_mode == 2'd0 && !meas_stb));

  assert_shutdown_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd2) |=> !meas_stb);

  assert_shutdown_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd2 && !startup_ok) |=> pm_mode == 2'd2);

  assert_shut_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_mode == 2'd1 && shut_req) |=> pm_mode == 2'd2);
endmodule

bind gauge_pwr_seq gauge_pwr_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sec_tick   (sec_tick),
  .fault      (fault),
  .shut_req   (shut_req),
  .startup_ok (startup_ok),
  .pm_mode    (pm_mode),
  .meas_stb   (meas_stb)
);

// File: tb/gauge_pwr_seq_test.sv
module gauge_pwr_seq_test;
  localparam int SMP_W = 16;
  localparam int IVL_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 0, smp_valid = 0, fault = 0, sleep_req = 0, shut_req = 0;
  logic startup_ok = 0, host_pres_n = 1;
  logic [SMP_W-1:0] smp_data = '0;
  logic [1:0] wake_sel = 2'd0;
  logic [IVL_W-1:0] sleep_ival = 8'd1;
  logic [1:0] pm_mode;
  logic meas_stb, sys_present;

  int checks = 0, errors = 0;
  bit q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  gauge_pwr_seq #(.SMP_W(SMP_W), .IVL_W(IVL_W)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .smp_valid(smp_valid),
    .smp_data(smp_data), .wake_sel(wake_sel), .sleep_ival(sleep_ival),
    .fault(fault), .sleep_req(sleep_req), .shut_req(shut_req),
    .startup_ok(startup_ok), .host_pres_n(host_pres_n),
    .pm_mode(pm_mode), .meas_stb(meas_stb), .sys_present(sys_present)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops the expected strobe for every sampled tick
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) begin
        automatic bit t = sec_tick;
        #2;
        if (t && q_exp.size() > 0) begin
          automatic bit e = q_exp.pop_front();
          automatic string g = q_tag.pop_front();
          chk(meas_stb, e, g);
        end else if (meas_stb) begin
          chk(meas_stb, 0, "R2 strobe without tick");
        end
      end
    end
  end

  // driver: one tick cycle with its expected strobe
  task automatic tick_step(input bit exp, input string tag);
    @(negedge clk);
    sec_tick = 1;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    sec_tick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic req_sleep();
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
  endtask

  task automatic apply_sample(input logic [1:0] sel, input int val);
    @(negedge clk);
    wake_sel = sel; smp_data = SMP_W'(val); smp_valid = 1;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic pulse_fault();
    @(negedge clk); fault = 1;
    @(negedge clk); fault = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk(pm_mode, 0, "R1 reset mode");
    chk(meas_stb, 0, "R1 reset strobe");
    chk(sys_present, 0, "R1 reset present");
    @(negedge clk); rst_n = 1;

    // normal mode strobes
    host_pres_n = 0;
    tick_step(1, "R2 normal tick 1");
    tick_step(1, "R2 normal tick 2");
    chk(sys_present, 1, "R9 present sampled low");
    idle(2);

    // enter sleep with interval 3
    sleep_ival = 8'd3;
    req_sleep();
    chk(pm_mode, 1, "R3 sleep entry");
    tick_step(0, "R4 ival3 t1");
    tick_step(0, "R4 ival3 t2");
    tick_step(1, "R4 ival3 t3");
    host_pres_n = 1;
    tick_step(0, "R4 ival3 t4");
    chk(sys_present, 0, "R9 present released");
    tick_step(0, "R4 ival3 t5");
    tick_step(1, "R4 ival3 t6");

    // below threshold stays asleep
    apply_sample(2'd0, 3);
    chk(pm_mode, 1, "R10 +3 below 4");
    apply_sample(2'd0, -3);
    chk(pm_mode, 1, "R10 -3 below 4");
    apply_sample(2'd3, 35);
    chk(pm_mode, 1, "R10 35 below 36");
    @(negedge clk); wake_sel = 2'd0; smp_data = SMP_W'(100); idle(1);
    chk(pm_mode, 1, "R10 valid low ignored");

    // current wake at exact threshold, positive
    apply_sample(2'd1, 9);
    chk(pm_mode, 0, "R5 wake +9 sel1");
    host_pres_n = 0;
    tick_step(1, "R6 tick after wake");
    chk(sys_present, 1, "R9 present after wake");

    req_sleep();
    apply_sample(2'd2, -18);
    chk(pm_mode, 0, "R5 wake -18 sel2");
    req_sleep();
    apply_sample(2'd3, -36);
    chk(pm_mode, 0, "R5 wake -36 sel3");
    req_sleep();
    apply_sample(2'd0, 4);
    chk(pm_mode, 0, "R5 wake +4 sel0");

    // fault wake with simultaneous tick
    req_sleep();
    @(negedge clk);
    fault = 1; sec_tick = 1;
    q_exp.push_back(0); q_tag.push_back("R6 no strobe on wake tick");
    @(negedge clk);
    fault = 0; sec_tick = 0;
    chk(pm_mode, 0, "R6 fault wake");
    tick_step(1, "R6 strobe next tick");

    // interval 0 acts as 1
    sleep_ival = 8'd0;
    req_sleep();
    tick_step(1, "R4 ival0 t1");
    tick_step(1, "R4 ival0 t2");
    pulse_fault();

    // count restarts on sleep entry
    sleep_ival = 8'd2;
    req_sleep();
    tick_step(0, "R4 restart pre");
    pulse_fault();
    chk(pm_mode, 0, "R6 fault wake 2");
    req_sleep();
    tick_step(0, "R4 restart t1");
    tick_step(1, "R4 restart t2");

    // shutdown beats wake
    @(negedge clk); shut_req = 1; fault = 1;
    @(negedge clk); shut_req = 0; fault = 0;
    chk(pm_mode, 2, "R8 shutdown over wake");

    // shutdown is inert
    host_pres_n = 1;
    tick_step(0, "R7 no strobe in shutdown 1");
    tick_step(0, "R7 no strobe in shutdown 2");
    chk(sys_present, 1, "R9 present held in shutdown");
    req_sleep();
    chk(pm_mode, 2, "R7 sleep_req ignored");
    pulse_fault();
    chk(pm_mode, 2, "R7 fault ignored");
    apply_sample(2'd0, 500);
    chk(pm_mode, 2, "R7 sample ignored");
    @(negedge clk); startup_ok = 1;
    @(negedge clk); startup_ok = 0;
    chk(pm_mode, 0, "R7 startup exit");
    tick_step(1, "R7 strobe after exit");
    chk(sys_present, 0, "R9 present after exit");

    // shutdown priority in normal
    @(negedge clk); shut_req = 1; sleep_req = 1;
    @(negedge clk); shut_req = 0; sleep_req = 0;
    chk(pm_mode, 2, "R3 shutdown over sleep");
    @(negedge clk); startup_ok = 1;
    @(negedge clk); startup_ok = 0;
    chk(pm_mode, 0, "R7 second exit");

    idle(3);
    chk(q_exp.size(), 0, "R2 all ticks observed");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule